// File: doc/BRIEF.md
# Bidirectional FIFO Command Controller

This block is the host-side control unit of a FIFO pair that moves data in both directions, one queue from side A to side B and one from B to A. Every host access carries an active-low chip select and a two-bit address. Together they route the access to FIFO data, to a narrow bypass path, to the currently selected configuration register, or to the status/command location. Writes to the command location are 16-bit command words. The block decodes each word into one-cycle strobes that the FIFO channels act on: pointer clears, mark and rewind loads, single-step increments and a DMA request clear. The block also keeps a DMA direction bit and the selection index for eight configuration registers.

Hardware reset and the software "reset everything" command do not give the same result. Hardware reset forces the DMA direction and the register selection back to their initial values. The software command keeps both and restores only the register contents. The FIFO storage, the flag threshold arithmetic and the bypass data path are outside this block. It only drives strobes and passes data through.

Top module: `bififo_cmd_ctrl`

## Requirements
- R1: With cs_ni low and addr_i = 2'b00, wr_i asserts ab_wr_o and places wdata_i on ab_wdata_o. rd_i asserts ba_rd_o and places ba_rdata_i on rdata_o. All of these are combinational.
- R2: With cs_ni low, addr_i = 2'b01 drives byp_wr_o or byp_rd_o, and a read returns byp_rdata_i zero-extended. addr_i = 2'b10 writes or reads the configuration register that is currently selected. A write takes effect at the clock edge.
- R3: With cs_ni low and addr_i = 2'b11, a read returns {flags_i, dma_dir_o}, with the direction in bit 0. The read changes no state and produces no strobe. A write at this address is a command word.
- R4: While cs_ni is high, no data or bypass strobe is asserted, rdata_o is zero, and no write changes any state. rdata_o is also zero when no read is active.
- R5: Opcode 4'b0000 is a reset command. The strobes pulse for one cycle, starting one clock after the write. Operand 001 pulses ba_ptr_rst_o. Operand 010 pulses ab_ptr_rst_o. Operand 011 pulses both. Operand 100 pulses only dma_req_clr_o. Operands 000, 101 and 110 produce nothing.
- R6: Opcode 4'b0001 selects configuration register 0 to 7 by its operand.
- R7: Opcode 4'b0110 sets dma_dir_o to operand bit 0, where 0 means B-to-A write and 1 means A-to-B read. No other command changes the direction.
- R8: Opcodes 4'b0010, 4'b0011, 4'b0100 and 4'b0101 pulse mark_rd_o, mark_wr_o, rewind_rd_o and rewind_wr_o respectively. Opcode 4'b1000 pulses ab_rd_inc_o and opcode 4'b1001 pulses ba_wr_inc_o. Each pulse starts one clock after the write and lasts one cycle.
- R9: Opcodes 4'b0111 and 4'b1010 to 4'b1111 change no state and produce no strobe.
- R10: Hardware reset (rst_ni low) sets register 4 to 16'h6420 and every other register to zero. It also clears the direction to 0 and the selection to 0. ba_ptr_rst_o, ab_ptr_rst_o and dma_req_clr_o stay high while reset is held.
- R11: Reset command operand 111 pulses all three reset strobes and restores every register to its hardware default. It leaves dma_dir_o and the register selection unchanged.
- R12: The opcode is wdata_i[15:12] and the operand is wdata_i[2:0]. Bits 11:3 of a command word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| cs_ni | input | 1 | Active-low chip select |
| addr_i | input | 2 | Resource select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data |
| flags_i | input | 15 | Flag bits reported in the status word |
| ba_rdata_i | input | 16 | Head data of the B-to-A FIFO |
| ab_wr_o | output | 1 | Push into the A-to-B FIFO |
| ab_wdata_o | output | 16 | Data for the A-to-B FIFO |
| ba_rd_o | output | 1 | Pop from the B-to-A FIFO |
| byp_rdata_i | input | BYP_W | Bypass path read data |
| byp_wr_o | output | 1 | Bypass write strobe |
| byp_rd_o | output | 1 | Bypass read strobe |
| byp_wdata_o | output | BYP_W | Bypass write data |
| ba_ptr_rst_o | output | 1 | Clear B-to-A pointers |
| ab_ptr_rst_o | output | 1 | Clear A-to-B pointers |
| dma_req_clr_o | output | 1 | Clear DMA request logic |
| mark_rd_o | output | 1 | Load reread pointer from read pointer |
| mark_wr_o | output | 1 | Load rewrite pointer from write pointer |
| rewind_rd_o | output | 1 | Load read pointer from reread pointer |
| rewind_wr_o | output | 1 | Load write pointer from rewrite pointer |
| ab_rd_inc_o | output | 1 | Step A-to-B read pointer once |
| ba_wr_inc_o | output | 1 | Step B-to-A write pointer once |
| dma_dir_o | output | 1 | DMA direction, 0 = B-to-A write |

## Verification
The command decoder is swept over all sixteen opcodes with all eight operands. Each word carries a different non-zero pattern in the ignored middle bits, and the nine-strobe vector is compared against a table computed in the bench. This sweep tells the reset operands apart from each other, the pointer loads from each other, and reserved codes from live ones. After every command, a status read and a configuration read show whether the direction and the selected register moved when they should not have. The reset-all operand is issued while the direction is 1 and every register holds a non-default value, which separates software reset from hardware reset. A second hardware reset mid-run confirms that the direction and the selection are forced back. Separate accesses with chip select high are compared against the same accesses with chip select low on the data, bypass and command paths.

// File: rtl/bififo_cmd_pkg.sv
`timescale 1ns/1ps
package bififo_cmd_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned ARG_W  = 3;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_BYP  = 2'b01,
    SEL_CFG  = 2'b10,
    SEL_CTRL = 2'b11
  } port_sel_e;

  typedef enum logic [OP_W-1:0] {
    OP_RESET     = 4'h0,
    OP_CFG_SEL   = 4'h1,
    OP_MARK_RD   = 4'h2,
    OP_MARK_WR   = 4'h3,
    OP_REWIND_RD = 4'h4,
    OP_REWIND_WR = 4'h5,
    OP_DMA_DIR   = 4'h6,
    OP_INC_AB_RD = 4'h8,
    OP_INC_BA_WR = 4'h9
  } cmd_op_e;

  typedef struct packed {
    logic rst_ba;
    logic rst_ab;
    logic dma_clr;
    logic mark_rd;
    logic mark_wr;
    logic rewind_rd;
    logic rewind_wr;
    logic inc_ab_rd;
    logic inc_ba_wr;
  } cmd_pulse_t;

  localparam cmd_pulse_t HW_RST_PULSE = '{rst_ba: 1'b1, rst_ab: 1'b1, dma_clr: 1'b1,
                                          default: 1'b0};

  function automatic logic [DATA_W-1:0] cfg_default(input int unsigned idx);
    return (idx == 4) ? 16'h6420 : '0;
  endfunction
endpackage

// File: rtl/bififo_port_decode.sv
`timescale 1ns/1ps
module bififo_port_decode
  import bififo_cmd_pkg::*;
(
  input  logic       cs_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic       ab_wr_o,
  output logic       ba_rd_o,
  output logic       byp_wr_o,
  output logic       byp_rd_o,
  output logic       cfg_wr_o,
  output logic       cmd_wr_o,
  output logic       rd_act_o
);
  logic hit;
  assign hit      = !cs_ni;
  assign ab_wr_o  = hit && wr_i && (port_sel_e'(addr_i) == SEL_DATA);
  assign ba_rd_o  = hit && rd_i && (port_sel_e'(addr_i) == SEL_DATA);
  assign byp_wr_o = hit && wr_i && (port_sel_e'(addr_i) == SEL_BYP);
  assign byp_rd_o = hit && rd_i && (port_sel_e'(addr_i) == SEL_BYP);
  assign cfg_wr_o = hit && wr_i && (port_sel_e'(addr_i) == SEL_CFG);
  assign cmd_wr_o = hit && wr_i && (port_sel_e'(addr_i) == SEL_CTRL);
  assign rd_act_o = hit && rd_i;
endmodule

// File: rtl/bififo_cmd_decode.sv
`timescale 1ns/1ps
module bififo_cmd_decode
  import bififo_cmd_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [ARG_W-1:0] arg_i,
  output cmd_pulse_t       pulse_o,
  output logic             dma_dir_o,
  output logic [SEL_W-1:0] cfg_sel_o,
  output logic             cfg_restore_o
);
  cmd_pulse_t pulse_d, pulse_q;
  logic       dir_q;
  logic [SEL_W-1:0] sel_q;

  always_comb begin
    pulse_d       = '0;
    cfg_restore_o = 1'b0;
    if (cmd_wr_i) begin
      case (cmd_op_e'(op_i))
        OP_RESET: begin
          case (arg_i)
            3'b001: pulse_d.rst_ba = 1'b1;
            3'b010: pulse_d.rst_ab = 1'b1;
            3'b011: begin pulse_d.rst_ba = 1'b1; pulse_d.rst_ab = 1'b1; end
            3'b100: pulse_d.dma_clr = 1'b1;
            3'b111: begin
              pulse_d.rst_ba  = 1'b1;
              pulse_d.rst_ab  = 1'b1;
              pulse_d.dma_clr = 1'b1;
              cfg_restore_o   = 1'b1;
            end
            default: ;
          endcase
        end
        OP_MARK_RD:   pulse_d.mark_rd   = 1'b1;
        OP_MARK_WR:   pulse_d.mark_wr   = 1'b1;
        OP_REWIND_RD: pulse_d.rewind_rd = 1'b1;
        OP_REWIND_WR: pulse_d.rewind_wr = 1'b1;
        OP_INC_AB_RD: pulse_d.inc_ab_rd = 1'b1;
        OP_INC_BA_WR: pulse_d.inc_ba_wr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= HW_RST_PULSE;
      dir_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      if (cmd_wr_i && cmd_op_e'(op_i) == OP_DMA_DIR) dir_q <= arg_i[0];
      if (cmd_wr_i && cmd_op_e'(op_i) == OP_CFG_SEL) sel_q <= arg_i[SEL_W-1:0];
    end
  end

  assign pulse_o   = pulse_q;
  assign dma_dir_o = dir_q;
  assign cfg_sel_o = sel_q;
endmodule

// File: rtl/bififo_cfg_file.sv
`timescale 1ns/1ps
module bififo_cfg_file
  import bififo_cmd_pkg::*;
#(
  parameter int unsigned NUM_CFG = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_CFG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              restore_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cfg_arr [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = cfg_default(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= RST_VAL;
      else if (restore_i)                    q <= RST_VAL;
      else if (wr_i && sel_i == SEL_W'(g))   q <= wdata_i;
    end
    assign cfg_arr[g] = q;
  end

  assign rdata_o = cfg_arr[sel_i];
endmodule

// File: rtl/bififo_cmd_ctrl.sv
`timescale 1ns/1ps
module bififo_cmd_ctrl
  import bififo_cmd_pkg::*;
#(
  parameter int unsigned BYP_W   = 9,
  parameter int unsigned NUM_CFG = 8,
  localparam int unsigned FLAG_W = DATA_W - 1,
  localparam int unsigned SEL_W  = $clog2(NUM_CFG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] ba_rdata_i,
  output logic              ab_wr_o,
  output logic [DATA_W-1:0] ab_wdata_o,
  output logic              ba_rd_o,
  input  logic [BYP_W-1:0]  byp_rdata_i,
  output logic              byp_wr_o,
  output logic              byp_rd_o,
  output logic [BYP_W-1:0]  byp_wdata_o,
  output logic              ba_ptr_rst_o,
  output logic              ab_ptr_rst_o,
  output logic              dma_req_clr_o,
  output logic              mark_rd_o,
  output logic              mark_wr_o,
  output logic              rewind_rd_o,
  output logic              rewind_wr_o,
  output logic              ab_rd_inc_o,
  output logic              ba_wr_inc_o,
  output logic              dma_dir_o
);
  logic              cfg_wr, cmd_wr, rd_act, restore, dir;
  logic [SEL_W-1:0]  cfg_sel;
  logic [DATA_W-1:0] cfg_rdata;
  cmd_pulse_t        pulse;

  bififo_port_decode u_dec (
    .cs_ni    (cs_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .ab_wr_o  (ab_wr_o),
    .ba_rd_o  (ba_rd_o),
    .byp_wr_o (byp_wr_o),
    .byp_rd_o (byp_rd_o),
    .cfg_wr_o (cfg_wr),
    .cmd_wr_o (cmd_wr),
    .rd_act_o (rd_act)
  );

  bififo_cmd_decode #(.SEL_W(SEL_W)) u_cmd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (cmd_wr),
    .op_i          (wdata_i[DATA_W-1 -: OP_W]),
    .arg_i         (wdata_i[ARG_W-1:0]),
    .pulse_o       (pulse),
    .dma_dir_o     (dir),
    .cfg_sel_o     (cfg_sel),
    .cfg_restore_o (restore)
  );

  bififo_cfg_file #(.NUM_CFG(NUM_CFG)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr),
    .restore_i (restore),
    .sel_i     (cfg_sel),
    .wdata_i   (wdata_i),
    .rdata_o   (cfg_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      case (port_sel_e'(addr_i))
        SEL_DATA: rdata_o = ba_rdata_i;
        SEL_BYP:  rdata_o = DATA_W'(byp_rdata_i);
        SEL_CFG:  rdata_o = cfg_rdata;
        SEL_CTRL: rdata_o = {flags_i, dir};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ab_wdata_o    = wdata_i;
  assign byp_wdata_o   = wdata_i[BYP_W-1:0];
  assign ba_ptr_rst_o  = pulse.rst_ba;
  assign ab_ptr_rst_o  = pulse.rst_ab;
  assign dma_req_clr_o = pulse.dma_clr;
  assign mark_rd_o     = pulse.mark_rd;
  assign mark_wr_o     = pulse.mark_wr;
  assign rewind_rd_o   = pulse.rewind_rd;
  assign rewind_wr_o   = pulse.rewind_wr;
  assign ab_rd_inc_o   = pulse.inc_ab_rd;
  assign ba_wr_inc_o   = pulse.inc_ba_wr;
  assign dma_dir_o     = dir;
endmodule

// File: rtl/bififo_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module bififo_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic [1:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [15:0] wdata_i,
  input logic        ab_wr_o,
  input logic        ba_rd_o,
  input logic        byp_wr_o,
  input logic        byp_rd_o,
  input logic        ba_ptr_rst_o,
  input logic        ab_ptr_rst_o,
  input logic        dma_req_clr_o,
  input logic        mark_rd_o,
  input logic        mark_wr_o,
  input logic        rewind_rd_o,
  input logic        rewind_wr_o,
  input logic        ab_rd_inc_o,
  input logic        ba_wr_inc_o,
  input logic        dma_dir_o
);
  logic cmd_wr;
  logic any_pulse;
  assign cmd_wr    = !cs_ni && wr_i && addr_i == 2'b11;
  assign any_pulse = ba_ptr_rst_o | ab_ptr_rst_o | dma_req_clr_o | mark_rd_o | mark_wr_o |
                     rewind_rd_o | rewind_wr_o | ab_rd_inc_o | ba_wr_inc_o;

  p_cs_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !(ab_wr_o || ba_rd_o || byp_wr_o || byp_rd_o));

  p_cs_no_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !any_pulse);

  p_status_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rd_i && !wr_i && addr_i == 2'b11) |=> !any_pulse);

  p_ptr_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mark_rd_o, mark_wr_o, rewind_rd_o, rewind_wr_o, ab_rd_inc_o, ba_wr_inc_o}));

  p_inc_ab_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[15:12] == 4'b1000) |=> ab_rd_inc_o);

  p_dir_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_wr && wdata_i[15:12] == 4'b0110) |=> $stable(dma_dir_o));

  p_reset_all_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[15:12] == 4'b0000 && wdata_i[2:0] == 3'b111)
      |=> (ba_ptr_rst_o && ab_ptr_rst_o && dma_req_clr_o && $stable(dma_dir_o)));
endmodule

bind bififo_cmd_ctrl bififo_cmd_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .addr_i        (addr_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .wdata_i       (wdata_i),
  .ab_wr_o       (ab_wr_o),
  .ba_rd_o       (ba_rd_o),
  .byp_wr_o      (byp_wr_o),
  .byp_rd_o      (byp_rd_o),
  .ba_ptr_rst_o  (ba_ptr_rst_o),
  .ab_ptr_rst_o  (ab_ptr_rst_o),
  .dma_req_clr_o (dma_req_clr_o),
  .mark_rd_o     (mark_rd_o),
  .mark_wr_o     (mark_wr_o),
  .rewind_rd_o   (rewind_rd_o),
  .rewind_wr_o   (rewind_wr_o),
  .ab_rd_inc_o   (ab_rd_inc_o),
  .ba_wr_inc_o   (ba_wr_inc_o),
  .dma_dir_o     (dma_dir_o)
);

// File: tb/bififo_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module bififo_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cs_n = 1'b1;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [14:0] flags = 15'h2B3C;
  logic [15:0] ba_rdata = 16'hBEEF;
  logic [8:0]  byp_rdata = 9'h15A;
  logic        ab_wr, ba_rd, byp_wr, byp_rd;
  logic [15:0] ab_wdata;
  logic [8:0]  byp_wdata;
  logic        ba_rst, ab_rst, dma_clr, mark_rd, mark_wr, rew_rd, rew_wr, ab_inc, ba_inc, dir;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_cfg [8];
  logic [2:0]  exp_sel;
  logic        exp_dir;

  always #5 clk = ~clk;

  bififo_cmd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .flags_i(flags), .ba_rdata_i(ba_rdata),
    .ab_wr_o(ab_wr), .ab_wdata_o(ab_wdata), .ba_rd_o(ba_rd), .byp_rdata_i(byp_rdata),
    .byp_wr_o(byp_wr), .byp_rd_o(byp_rd), .byp_wdata_o(byp_wdata),
    .ba_ptr_rst_o(ba_rst), .ab_ptr_rst_o(ab_rst), .dma_req_clr_o(dma_clr),
    .mark_rd_o(mark_rd), .mark_wr_o(mark_wr), .rewind_rd_o(rew_rd), .rewind_wr_o(rew_wr),
    .ab_rd_inc_o(ab_inc), .ba_wr_inc_o(ba_inc), .dma_dir_o(dir)
  );

  wire [8:0] pv = {ba_rst, ab_rst, dma_clr, mark_rd, mark_wr, rew_rd, rew_wr, ab_inc, ba_inc};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Expected strobe vector for one command word, bit order as pv.
  function automatic logic [8:0] exp_pulse(input int op, input int arg);
    logic [8:0] v = '0;
    case (op)
      0: case (arg)
           1: v[8] = 1'b1;
           2: v[7] = 1'b1;
           3: v[8:7] = 2'b11;
           4: v[6] = 1'b1;
           7: v[8:6] = 3'b111;
           default: ;
         endcase
      2: v[5] = 1'b1;
      3: v[4] = 1'b1;
      4: v[3] = 1'b1;
      5: v[2] = 1'b1;
      8: v[1] = 1'b1;
      9: v[0] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d, output logic stb,
                        input logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; addr = a; rd = 1'b1;
    #1;
    d = rdata;
    stb = (a == 2'b00) ? ba_rd : (a == 2'b01) ? byp_rd : 1'b0;
    @(negedge clk);
    cs_n = 1'b1; rd = 1'b0;
  endtask

  task automatic do_hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 strobes held in reset", 32'(pv), 32'h1C0);
    check("R10 dir in reset", 32'(dir), 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) exp_cfg[i] = (i == 4) ? 16'h6420 : 16'h0000;
    exp_sel = 3'd0;
    exp_dir = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic stb;
    #2;
    do_hw_reset();
    @(negedge clk);
    check("R10 strobes clear after reset", 32'(pv), 32'h0);
    bus_rd(2'b11, d, stb);
    check("R3 status after reset", 32'(d), {16'h0, flags, 1'b0});
    bus_rd(2'b10, d, stb);
    check("R10 reg0 default", 32'(d), 32'h0);
    bus_wr(2'b11, 16'h1004);
    bus_rd(2'b10, d, stb);
    check("R10 reg4 default", 32'(d), 32'h6420);

    // R1 data path
    @(negedge clk);
    cs_n = 1'b0; addr = 2'b00; wr = 1'b1; wdata = 16'hC3A5; #1;
    check("R1 ab push", 32'({ab_wr, ab_wdata}), {15'h0, 1'b1, 16'hC3A5});
    @(negedge clk); cs_n = 1'b1; wr = 1'b0;
    bus_rd(2'b00, d, stb);
    check("R1 ba pop data", 32'({stb, d}), {15'h0, 1'b1, 16'hBEEF});
    // R2 bypass
    @(negedge clk);
    cs_n = 1'b0; addr = 2'b01; wr = 1'b1; wdata = 16'hFE6B; #1;
    check("R2 bypass write", 32'({byp_wr, ab_wr, byp_wdata}), {21'h0, 2'b10, 9'h06B});
    @(negedge clk); cs_n = 1'b1; wr = 1'b0;
    bus_rd(2'b01, d, stb);
    check("R2 bypass read", 32'({stb, d}), {15'h0, 1'b1, 16'h015A});
    // R4 chip select high
    @(negedge clk);
    cs_n = 1'b1; addr = 2'b00; wr = 1'b1; wdata = 16'h1234; #1;
    check("R4 no push when deselected", 32'({ab_wr, byp_wr}), 32'h0);
    @(negedge clk); wr = 1'b0;
    bus_rd(2'b00, d, stb, 1'b1);
    check("R4 read deselected", 32'({stb, d}), 32'h0);
    bus_wr(2'b11, 16'h6001, 1'b1);
    check("R4 command ignored deselected", 32'(pv), 32'h0);
    bus_wr(2'b10, 16'hDEAD, 1'b1);
    bus_rd(2'b10, d, stb);
    check("R4 cfg write ignored deselected", 32'(d), 32'h6420);
    bus_rd(2'b11, d, stb);
    check("R4 dir unchanged", 32'(d[0]), 32'h0);
    @(negedge clk);
    check("R4 rdata zero when idle", 32'(rdata), 32'h0);

    // R12: filler bits set, operand 000
    bus_wr(2'b11, 16'h8FF8);
    check("R12 ignored middle bits", 32'(pv), 32'h002);
    bus_wr(2'b11, 16'h6FF9);
    bus_rd(2'b11, d, stb);
    check("R12 operand from low bits", 32'(d[0]), 32'h1);
    exp_dir = 1'b1;

    // Preload registers with non-default values (R2, R6)
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'b11, {4'h1, 9'h0, 3'(i)});
      bus_wr(2'b10, 16'hA000 | 16'(i));
      exp_cfg[i] = 16'hA000 | 16'(i);
    end
    exp_sel = 3'd7;
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'b11, {4'h1, 9'h155, 3'(i)});
      bus_rd(2'b10, d, stb);
      check("R2 cfg readback", 32'(d), 32'(exp_cfg[i]));
    end

    // Full opcode x operand sweep (R5 R6 R7 R8 R9 R11)
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 8; a++) begin
        string tag;
        logic [8:0] fill;
        fill = 9'((op * 37 + a * 11 + 1) % 512);
        tag = (op == 0) ? ((a == 7) ? "R11" : "R5") : (op == 1) ? "R6" : (op == 6) ? "R7" :
              (op == 7 || op > 9) ? "R9" : "R8";
        bus_wr(2'b11, {4'(op), fill, 3'(a)});
        check({tag, " strobes"}, 32'(pv), 32'(exp_pulse(op, a)));
        if (op == 6) exp_dir = a[0];
        if (op == 1) exp_sel = 3'(a);
        if (op == 0 && a == 7)
          for (int i = 0; i < 8; i++) exp_cfg[i] = (i == 4) ? 16'h6420 : 16'h0000;
        bus_rd(2'b11, d, stb);
        check({tag, " status dir"}, 32'(d), {16'h0, flags, exp_dir});
        check("R3 status read quiet", 32'(pv), 32'h0);
        bus_rd(2'b10, d, stb);
        check({tag, " cfg selected"}, 32'(d), 32'(exp_cfg[exp_sel]));
      end
    end

    // Hardware reset forces dir and selection (R10)
    bus_wr(2'b11, 16'h1002);
    bus_wr(2'b10, 16'h5555);
    do_hw_reset();
    bus_rd(2'b11, d, stb);
    check("R10 dir forced", 32'(d[0]), 32'h0);
    bus_rd(2'b10, d, stb);
    check("R10 selection forced", 32'(d), 32'h0);
    bus_wr(2'b11, 16'h1002);
    bus_rd(2'b10, d, stb);
    check("R10 reg2 cleared", 32'(d), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule